// File: doc/BRIEF.md
# Return Address Stack Predictor

This block predicts the target of subroutine returns for an instruction fetch unit. A return is an indirect jump through a register, so its target changes at run time and a target cache indexed by fetch address predicts it poorly. The block keeps the return addresses in a small circular stack instead. When fetch sees a call, it pushes the address of the instruction after the call (call address plus 4). When fetch sees a return, it pops, and the entry that was on top is the predicted target. If the stack holds nothing, the valid flag drops and fetch uses its ordinary branch predictor.

Fetch runs ahead of branch resolution, so calls and returns on a wrong path move the stack pointer and can overwrite a slot that the correct path still needs. For this reason the block shows its top pointer, its occupancy and its top entry at all times. Fetch stores these three values with each predicted branch. When a branch turns out to be mispredicted, fetch returns the stored values through a restore strobe. In one cycle the block writes the pointer, the occupancy and the entry in the top slot back, and this undoes any corruption of the slot the correct path uses next.

Top module: `ret_stack`

## Requirements
- R1: After reset the stack is empty: `predValid` is 0 and `snapCount` is 0.
- R2: When `callValid` is high, the cycle after the edge shows `predValid` = 1 and `predTarget` = `callPc` + 4.
- R3: When `retValid` is high on a non-empty stack, the top entry is removed. Entries come back in last-in, first-out order, and the occupancy drops by one.
- R4: When `retValid` is high on an empty stack, nothing happens: `predValid` stays 0, and a later push behaves as it would on a stack that was never popped.
- R5: The stack holds 8 entries in a ring. A push to a full stack overwrites the oldest entry and the occupancy stays at 8. After 8 pops, `predValid` is 0.
- R6: When `callValid` and `retValid` are high in the same cycle, only the push takes place.
- R7: `snapPtr` and `snapCount` always show the current top slot index and the occupancy, and `predTarget` shows the entry in the top slot. When `restoreValid` is high, the next cycle shows `snapPtr` = `restorePtr`, `snapCount` = `restoreCount` and `predTarget` = `restoreTop`. This holds even if wrong-path pushes overwrote that slot.
- R8: A restore takes priority over a call or a return in the same cycle, and the call or return is then dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| callValid | input | 1 | Fetch saw a call this cycle |
| callPc | input | 32 | Address of the call instruction |
| retValid | input | 1 | Fetch saw a return this cycle |
| restoreValid | input | 1 | Misspeculation repair strobe |
| restorePtr | input | 3 | Saved top slot index |
| restoreCount | input | 4 | Saved occupancy (0 to 8) |
| restoreTop | input | 32 | Saved top entry |
| predValid | output | 1 | Stack is non-empty, so the prediction is usable |
| predTarget | output | 32 | Predicted return target (top entry) |
| snapPtr | output | 3 | Current top slot index, for checkpointing |
| snapCount | output | 4 | Current occupancy, for checkpointing |

## Verification
The hardest case to reach is a wrong-path push that overwrites the exact slot a checkpoint refers to. The pointer must first move down and then move back up over the saved slot before the restore arrives. The stimulus builds three entries and takes a checkpoint. It then pops once and pushes a different address, which replaces the saved top in its slot. After the restore, the bench expects the original top and then the entry below it. A second case runs the stack past full: it wraps the ring, drains it, and checks that the overwritten oldest entry never comes back.

// File: rtl/ret_stack_pkg.sv
package ret_stack_pkg;
  typedef struct packed {
    logic doPush;
    logic doPop;
    logic doRestore;
  } rasStrobe_t;
endpackage

// File: rtl/ret_stack_ctrl.sv
module ret_stack_ctrl
  import ret_stack_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             callValid,
  input  logic             retValid,
  input  logic             restoreValid,
  input  logic [PTR_W-1:0] restorePtr,
  input  logic [CNT_W-1:0] restoreCount,
  output rasStrobe_t       strobe,
  output logic [PTR_W-1:0] nextPtr,
  output logic [PTR_W-1:0] topPtr,
  output logic [CNT_W-1:0] count
);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [PTR_W-1:0] ptrUp;
  logic [PTR_W-1:0] ptrDown;
  logic [CNT_W-1:0] nextCount;
  logic             isEmpty;

  assign isEmpty = (count == '0);
  assign ptrUp   = (topPtr == LAST_IDX) ? '0 : topPtr + 1'b1;
  assign ptrDown = (topPtr == '0) ? LAST_IDX : topPtr - 1'b1;

  // Priority: restore, then push, then pop (pop ignored when empty)
  always_comb begin
    strobe.doRestore = restoreValid;
    strobe.doPush    = callValid && !restoreValid;
    strobe.doPop     = retValid && !callValid && !restoreValid && !isEmpty;
  end

  always_comb begin
    nextPtr   = topPtr;
    nextCount = count;
    if (strobe.doRestore) begin
      nextPtr   = restorePtr;
      nextCount = restoreCount;
    end else if (strobe.doPush) begin
      nextPtr   = ptrUp;
      nextCount = (count == FULL_CNT) ? FULL_CNT : count + 1'b1;
    end else if (strobe.doPop) begin
      nextPtr   = ptrDown;
      nextCount = count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      topPtr <= '0;
      count  <= '0;
    end else begin
      topPtr <= nextPtr;
      count  <= nextCount;
    end
  end
endmodule

// File: rtl/ret_stack_dp.sv
module ret_stack_dp
  import ret_stack_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  rasStrobe_t       strobe,
  input  logic [PTR_W-1:0] nextPtr,
  input  logic [PTR_W-1:0] topPtr,
  input  logic [AW-1:0]    callPc,
  input  logic [AW-1:0]    restoreTop,
  output logic [AW-1:0]    topEntry
);
  localparam logic [AW-1:0] INSN_BYTES = AW'(4);

  logic [AW-1:0] slots [DEPTH];
  logic [AW-1:0] wrData;
  logic          wrEn;

  assign wrEn   = strobe.doPush || strobe.doRestore;
  assign wrData = strobe.doRestore ? restoreTop : callPc + INSN_BYTES;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [AW-1:0] slotQ;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        slotQ <= '0;
      end else if (wrEn && nextPtr == PTR_W'(i)) begin
        slotQ <= wrData;
      end
    end
    assign slots[i] = slotQ;
  end

  assign topEntry = slots[topPtr];
endmodule

// File: rtl/ret_stack.sv
module ret_stack
  import ret_stack_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             callValid,
  input  logic [AW-1:0]    callPc,
  input  logic             retValid,
  input  logic             restoreValid,
  input  logic [PTR_W-1:0] restorePtr,
  input  logic [CNT_W-1:0] restoreCount,
  input  logic [AW-1:0]    restoreTop,
  output logic             predValid,
  output logic [AW-1:0]    predTarget,
  output logic [PTR_W-1:0] snapPtr,
  output logic [CNT_W-1:0] snapCount
);
  rasStrobe_t       strobe;
  logic [PTR_W-1:0] nextPtr;
  logic [PTR_W-1:0] topPtr;
  logic [CNT_W-1:0] curCount;

  ret_stack_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .callValid(callValid), .retValid(retValid),
    .restoreValid(restoreValid), .restorePtr(restorePtr),
    .restoreCount(restoreCount),
    .strobe(strobe), .nextPtr(nextPtr), .topPtr(topPtr), .count(curCount)
  );

  ret_stack_dp #(.DEPTH(DEPTH), .AW(AW)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .nextPtr(nextPtr),
    .topPtr(topPtr), .callPc(callPc), .restoreTop(restoreTop),
    .topEntry(predTarget)
  );

  assign predValid = (curCount != '0);
  assign snapPtr   = topPtr;
  assign snapCount = curCount;
endmodule

// File: rtl/ret_stack_checker.sv
module ret_stack_checker #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             callValid,
  input logic [AW-1:0]    callPc,
  input logic             retValid,
  input logic             restoreValid,
  input logic [PTR_W-1:0] restorePtr,
  input logic [CNT_W-1:0] restoreCount,
  input logic [AW-1:0]    restoreTop,
  input logic             predValid,
  input logic [AW-1:0]    predTarget,
  input logic [PTR_W-1:0] snapPtr,
  input logic [CNT_W-1:0] snapCount
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  assert_push_top_R2: assert property (@(posedge clk) disable iff (!rstN)
    callValid && !restoreValid |=> predValid && predTarget == $past(callPc) + AW'(4));

  assert_pop_shrink_R3: assert property (@(posedge clk) disable iff (!rstN)
    retValid && !callValid && !restoreValid && snapCount != '0
      |=> snapCount == $past(snapCount) - 1'b1);

  assert_empty_pop_R4: assert property (@(posedge clk) disable iff (!rstN)
    retValid && !callValid && !restoreValid && snapCount == '0 |=> !predValid);

  assert_bounded_R5: assert property (@(posedge clk) disable iff (!rstN)
    snapCount <= FULL_CNT);

  assert_full_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    callValid && !restoreValid && snapCount == FULL_CNT |=> snapCount == FULL_CNT);

  assert_push_wins_R6: assert property (@(posedge clk) disable iff (!rstN)
    callValid && retValid && !restoreValid && snapCount != FULL_CNT
      |=> snapCount == $past(snapCount) + 1'b1);

  assert_restore_R7: assert property (@(posedge clk) disable iff (!rstN)
    restoreValid |=> snapPtr == $past(restorePtr) && snapCount == $past(restoreCount)
                     && predTarget == $past(restoreTop));
endmodule

bind ret_stack ret_stack_checker #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk(clk), .rstN(rstN), .callValid(callValid), .callPc(callPc),
  .retValid(retValid), .restoreValid(restoreValid), .restorePtr(restorePtr),
  .restoreCount(restoreCount), .restoreTop(restoreTop), .predValid(predValid),
  .predTarget(predTarget), .snapPtr(snapPtr), .snapCount(snapCount)
);

// File: tb/ret_stack_test.sv
`timescale 1ns/1ps
module ret_stack_test;
  localparam int DEPTH = 8;
  localparam int AW = 32;

  logic clk = 0;
  logic rstN = 0;
  logic callValid = 0, retValid = 0, restoreValid = 0;
  logic [AW-1:0] callPc = '0, restoreTop = '0;
  logic [2:0] restorePtr = '0;
  logic [3:0] restoreCount = '0;
  logic predValid;
  logic [AW-1:0] predTarget;
  logic [2:0] snapPtr;
  logic [3:0] snapCount;

  always #2.5 clk = ~clk;

  ret_stack uut (
    .clk(clk), .rstN(rstN), .callValid(callValid), .callPc(callPc),
    .retValid(retValid), .restoreValid(restoreValid), .restorePtr(restorePtr),
    .restoreCount(restoreCount), .restoreTop(restoreTop),
    .predValid(predValid), .predTarget(predTarget),
    .snapPtr(snapPtr), .snapCount(snapCount)
  );

  typedef struct {
    logic          v;
    logic [AW-1:0] t;
    string         tag;
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // Reference model, written from the requirements
  logic [AW-1:0] m [DEPTH];
  int mPtr = 0;
  int mCnt = 0;

  task automatic check(input bit ok, input string tag, input logic [AW-1:0] act,
                       input logic [AW-1:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // Monitor: compares each queued expectation on the falling edge
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      expItem_t e;
      e = expQ.pop_front();
      check(predValid == e.v, {e.tag, " valid"}, AW'(predValid), AW'(e.v));
      if (e.v) check(predTarget == e.t, {e.tag, " target"}, predTarget, e.t);
    end
  end

  // Driver: applies one cycle of stimulus and queues the expected outcome
  task automatic drive(input bit c, input logic [AW-1:0] pc, input bit r,
                       input bit rs, input int rp, input int rc,
                       input logic [AW-1:0] rt, input string tag);
    expItem_t e;
    @(negedge clk);
    callValid = c; callPc = pc; retValid = r;
    restoreValid = rs; restorePtr = 3'(rp); restoreCount = 4'(rc); restoreTop = rt;
    @(posedge clk);
    if (rs) begin
      mPtr = rp; mCnt = rc; m[rp] = rt;
    end else if (c) begin
      mPtr = (mPtr + 1) % DEPTH; m[mPtr] = pc + 4;
      if (mCnt < DEPTH) mCnt++;
    end else if (r && mCnt > 0) begin
      mPtr = (mPtr + DEPTH - 1) % DEPTH; mCnt--;
    end
    e.v = (mCnt != 0); e.t = m[mPtr]; e.tag = tag;
    expQ.push_back(e);
    #1;
    callValid = 0; retValid = 0; restoreValid = 0;
  endtask

  task automatic push(input logic [AW-1:0] pc, input string tag);
    drive(1, pc, 0, 0, 0, 0, '0, tag);
  endtask
  task automatic pop(input string tag);
    drive(0, '0, 1, 0, 0, 0, '0, tag);
  endtask
  task automatic settle();
    @(negedge clk); @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int sp, sc;
    logic [AW-1:0] st;
    for (int i = 0; i < DEPTH; i++) m[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    @(negedge clk);
    // R1: reset state
    check(predValid == 0, "R1 reset valid", AW'(predValid), 0);
    check(snapCount == 0, "R1 reset count", AW'(snapCount), 0);

    // R4: pop on empty stack ignored
    pop("R4 empty pop");
    settle();
    check(snapCount == 0, "R4 count after empty pop", AW'(snapCount), 0);

    // R2: push makes call address + 4 the top
    push(32'h0000_1000, "R2 push");
    // R3: LIFO order
    push(32'h0000_2000, "R3 push b");
    push(32'h0000_3000, "R3 push c");
    pop("R3 pop c");
    pop("R3 pop b");
    pop("R3 pop a");
    pop("R4 pop past empty");
    push(32'h0000_4440, "R4 push after empty pop");
    pop("R4 drain");
    settle();

    // R5: overflow wraps, oldest entries lost
    for (int i = 0; i < 10; i++) push(32'h0001_0000 + 32'(i) * 32'h10, "R5 fill");
    settle();
    check(snapCount == 4'd8, "R5 saturated count", AW'(snapCount), 8);
    for (int i = 0; i < 8; i++) pop("R5 drain");
    pop("R5 empty after 8 pops");
    settle();

    // R6: push and pop together -> push only
    push(32'h0000_5000, "R6 base");
    drive(1, 32'h0000_6000, 1, 0, 0, 0, '0, "R6 push wins");
    settle();
    check(snapCount == 4'd2, "R6 count", AW'(snapCount), 2);
    pop("R6 pop1");
    pop("R6 pop2");

    // R7: checkpoint, wrong-path corruption, restore
    push(32'h0000_a000, "R7 a");
    push(32'h0000_b000, "R7 b");
    push(32'h0000_c000, "R7 c");
    settle();
    check(snapPtr == 3'(mPtr), "R7 snapPtr", AW'(snapPtr), AW'(mPtr));
    check(snapCount == 4'(mCnt), "R7 snapCount", AW'(snapCount), AW'(mCnt));
    sp = snapPtr; sc = snapCount; st = predTarget;
    check(st == 32'h0000_c004, "R7 snap top", st, 32'h0000_c004);
    pop("R7 wrong-path pop");
    push(32'h0000_dead, "R7 wrong-path overwrite");
    push(32'h0000_beef, "R7 wrong-path push");
    drive(0, '0, 0, 1, sp, sc, st, "R7 restore");
    pop("R7 after restore pop");

    // R8: restore beats a simultaneous call
    settle();
    sp = snapPtr; sc = snapCount; st = predTarget;
    push(32'h0000_7000, "R8 pre");
    drive(1, 32'h0000_8000, 0, 1, sp, sc, st, "R8 restore over call");
    settle();
    check(snapCount == 4'(sc), "R8 count", AW'(snapCount), AW'(sc));
    pop("R8 pop");
    pop("R8 empty");
    settle();

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule